// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a two-wire serial bus engine and a byte-wide nonvolatile array. The engine opens a write transaction by pulsing `wr_start` together with a word address. Each data byte that follows is placed in a small page latch, at the slot named by the low address bits. A per-slot valid mask records which slots hold new data. The pointer steps by one within the page, so a transaction that runs past the page length wraps around and overwrites its own earlier bytes. The page number in the upper address bits never changes during a transaction.

When the engine reports a stop and at least one byte was accepted, the block starts a timed internal write cycle. During that cycle it raises `busy` and sends only the marked slots to the array, one registered strobe per byte. The cycle length is a parameter counted in system clocks. While `busy` is high every input is ignored. A write-protect level blocks bytes from being latched, so a protected transaction never starts a cycle. After the cycle, `word_ptr` holds the address that follows the last byte accepted, kept inside the page.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and `word_ptr` is 0.
- R2: `wr_start` loads `word_ptr` with `wr_addr`. Each accepted byte goes to slot `word_ptr[3:0]`, and then only those four low bits increment, wrapping from 15 to 0. Bits [7:4] keep the page of the loaded address.
- R3: When more than 16 bytes arrive in one transaction, a later byte replaces the earlier byte in the same slot, and only the newest value is written to the array.
- R4: A commit writes each marked slot exactly once and no unmarked slot. Slots are written in ascending order 0 to 15, at address {page, slot}, with `arr_wdata` holding the latched byte while `arr_we` is high.
- R5: A stop that follows at least one accepted byte raises `busy` on the next clock edge. `busy` then stays high for exactly `WR_CYCLES` cycles, and every `arr_we` pulse falls inside that window.
- R6: A stop in a transaction with no accepted byte leaves `busy` low and produces no array write.
- R7: A byte presented while `wp_level` is high is not latched and does not move `word_ptr`. A transaction whose bytes were all protected starts no write cycle.
- R8: While `busy` is high, `wr_start`, `byte_vld` and `stop_evt` have no effect. `word_ptr` is unchanged and no extra array write follows.
- R9: A new `wr_start` clears the valid mask, so a transaction restarted before its stop commits only the bytes received after the restart.
- R10: After a commit, `word_ptr` equals the page of the transaction combined with (start slot + number of accepted bytes) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Pulse that opens a write transaction |
| wr_addr | input | ADDR_W | Word address loaded on `wr_start` |
| byte_vld | input | 1 | Pulse marking a received data byte |
| byte_data | input | DATA_W | Data byte qualified by `byte_vld` |
| stop_evt | input | 1 | Pulse marking the end of the transaction |
| wp_level | input | 1 | Write-protect level; high blocks byte latching |
| arr_we | output | 1 | Array write strobe, one cycle per committed byte |
| arr_addr | output | ADDR_W | Array address for `arr_we` |
| arr_wdata | output | DATA_W | Array data for `arr_we` |
| busy | output | 1 | High during the timed internal write cycle |
| word_ptr | output | ADDR_W | Current word address pointer |

## Verification
The hardest state to reach is a page that wraps and is then committed. In that case every slot is marked, some slots have been overwritten, and the pointer has wrapped back into the same page. The stimulus starts near the top of a page and pushes twenty bytes with distinct values, so a stale byte that reaches the array is easy to tell from the newest one. A second difficult case is a restart before the stop. Bytes from the abandoned transaction must not leak into the commit, so the bench opens a transaction, sends bytes, reopens at another slot and stops. Traffic issued while `busy` is high is driven in the middle of a commit, to show that nothing from it reaches the array.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_OPEN   = 2'd1,
    TX_COMMIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_i) begin
      ptr_q <= ld_addr_i;
    end else if (inc_i) begin
      // only the slot bits advance; the page bits hold
      ptr_q[SLOT_W-1:0] <= ptr_q[SLOT_W-1:0] + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> $stable(ptr_q[ADDR_W-1:SLOT_W]));
endmodule

// File: rtl/pgbuf_latch.sv
module pgbuf_latch #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              rd_vld_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [SLOTS-1:0]  mask_o
);
  logic [DATA_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0]  mask_q;
  logic [DATA_W-1:0] rd_q;
  logic              hit_q;
  logic              vld_q;
  logic [SLOT_W-1:0] slot_q;

  // storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_slot_i] <= wr_data_i;
    end
    rd_q <= mem[rd_slot_i];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        mask_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_slot_i == SLOT_W'(g))) begin
        mask_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      vld_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      hit_q  <= mask_q[rd_slot_i];
      vld_q  <= rd_en_i;
      slot_q <= rd_slot_i;
    end
  end

  assign rd_data_o = rd_q;
  assign rd_hit_o  = hit_q;
  assign rd_vld_o  = vld_q;
  assign rd_slot_o = slot_q;
  assign mask_o    = mask_q;

  // R9
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (mask_q == '0));
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int WR_CYCLES  = 40,
  parameter int PAGE_BYTES = 16,
  parameter int SLOT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              scan_en_o,
  output logic [SLOT_W-1:0] scan_slot_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == CNT_W'(WR_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign scan_en_o   = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_slot_o = cnt_q[SLOT_W-1:0];

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(go_i));
  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(done_o));
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              wp_level,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] word_ptr
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  tx_state_e state_q, state_d;

  logic              load, accept, go;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE_BYTES-1:0] mask;
  logic              tmr_busy, tmr_done, scan_en;
  logic [SLOT_W-1:0] scan_slot;
  logic [DATA_W-1:0] rd_data;
  logic              rd_hit, rd_vld;
  logic [SLOT_W-1:0] rd_slot;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign load   = wr_start && (state_q != TX_COMMIT);
  assign accept = (state_q == TX_OPEN) && byte_vld && !wp_level
                  && !wr_start && !stop_evt;
  assign go     = (state_q == TX_OPEN) && stop_evt && !wr_start && (|mask);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE: begin
        if (wr_start) state_d = TX_OPEN;
      end
      TX_OPEN: begin
        if (wr_start)      state_d = TX_OPEN;
        else if (go)       state_d = TX_COMMIT;
        else if (stop_evt) state_d = TX_IDLE;
      end
      TX_COMMIT: begin
        if (tmr_done) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TX_IDLE;
    else     state_q <= state_d;
  end

  pgbuf_ptr #(
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W)
  ) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (load),
    .ld_addr_i (wr_addr),
    .inc_i     (accept),
    .ptr_o     (ptr)
  );

  pgbuf_latch #(
    .SLOTS  (PAGE_BYTES),
    .SLOT_W (SLOT_W),
    .DATA_W (DATA_W)
  ) u_latch (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (load),
    .wr_en_i   (accept),
    .wr_slot_i (ptr[SLOT_W-1:0]),
    .wr_data_i (byte_data),
    .rd_en_i   (scan_en),
    .rd_slot_i (scan_slot),
    .rd_data_o (rd_data),
    .rd_hit_o  (rd_hit),
    .rd_vld_o  (rd_vld),
    .rd_slot_o (rd_slot),
    .mask_o    (mask)
  );

  pgbuf_timer #(
    .WR_CYCLES  (WR_CYCLES),
    .PAGE_BYTES (PAGE_BYTES),
    .SLOT_W     (SLOT_W)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .busy_o      (tmr_busy),
    .done_o      (tmr_done),
    .scan_en_o   (scan_en),
    .scan_slot_o (scan_slot)
  );

  // registered array interface; page bits come from the held pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q    <= rd_vld && rd_hit;
      addr_q  <= {ptr[ADDR_W-1:SLOT_W], rd_slot};
      wdata_q <= rd_data;
    end
  end

  assign arr_we    = we_q;
  assign arr_addr  = addr_q;
  assign arr_wdata = wdata_q;
  assign busy      = tmr_busy;
  assign word_ptr  = ptr;

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  // R8
  busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(word_ptr));
  // R6
  empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_OPEN && stop_evt && !wr_start && mask == '0) |=> !busy);
  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wp_level && byte_vld && !wr_start && state_q != TX_COMMIT) |=> $stable(word_ptr));
  // R4
  we_page_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_addr[ADDR_W-1:SLOT_W] == word_ptr[ADDR_W-1:SLOT_W]));

  logic [PAGE_W-1:0] unused_page;
  assign unused_page = ptr[ADDR_W-1:SLOT_W];
endmodule

// File: tb/tb_page_commit_buf.sv
module tb_page_commit_buf;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PAGE   = 16;
  localparam int WRC    = 40;

  logic clk = 1'b0;
  logic rst;
  logic wr_start, byte_vld, stop_evt, wp_level;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] byte_data;
  logic arr_we, busy;
  logic [ADDR_W-1:0] arr_addr, word_ptr;
  logic [DATA_W-1:0] arr_wdata;

  always #2.5 clk = ~clk;

  page_commit_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
    .wp_level(wp_level), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .busy(busy), .word_ptr(word_ptr));

  typedef struct { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [DATA_W-1:0] m_data [PAGE];
  logic [PAGE-1:0]   m_mask;
  logic [ADDR_W-1:0] m_ptr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected write actual=%0h:%0h expected=none", arr_addr, arr_wdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (arr_addr !== it.a || arr_wdata !== it.d || busy !== 1'b1) begin
          errors++;
          $display("FAIL R4/R5 write actual=%0h:%0h busy=%0b expected=%0h:%0h busy=1",
                   arr_addr, arr_wdata, busy, it.a, it.d);
        end
      end
    end
  end

  task automatic do_start(input logic [ADDR_W-1:0] a);
    wr_start = 1'b1; wr_addr = a;
    @(negedge clk); wr_start = 1'b0;
    m_ptr = a; m_mask = '0;
  endtask

  task automatic send(input logic [DATA_W-1:0] d);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
    if (!wp_level) begin
      m_data[m_ptr[3:0]] = d;
      m_mask[m_ptr[3:0]] = 1'b1;
      m_ptr[3:0] = m_ptr[3:0] + 1'b1;
    end
  endtask

  // stop, then follow the commit window; expected writes pushed first
  task automatic do_stop(input string req);
    int n;
    for (int s = 0; s < PAGE; s++)
      if (m_mask[s]) begin
        item_t it;
        it.a = {m_ptr[7:4], 4'(s)}; it.d = m_data[s];
        sb_q.push_back(it);
      end
    stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    if (m_mask != '0) begin
      check({req, " R5 busy rises"}, busy, 1'b1);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check({req, " R5 busy length"}, n, WRC);
    end else begin
      for (int k = 0; k < 5; k++) begin
        if (busy) n = 1;
        @(negedge clk);
      end
      check({req, " R6/R7 no cycle"}, busy, 1'b0);
    end
    check({req, " R4 all writes seen"}, sb_q.size(), 0);
    check({req, " R10 word_ptr"}, word_ptr, m_ptr);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_start = 0; byte_vld = 0; stop_evt = 0; wp_level = 0;
    wr_addr = '0; byte_data = '0; m_mask = '0; m_ptr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 busy", busy, 0);
    check("R1 arr_we", arr_we, 0);
    check("R1 word_ptr", word_ptr, 0);

    // R2, R4: short transaction
    do_start(8'h35);
    check("R2 load", word_ptr, 8'h35);
    send(8'hA1); send(8'hB2); send(8'hC3);
    check("R2 advance", word_ptr, 8'h38);
    do_stop("short");

    // R3, R2: wrap with 20 bytes from slot 12
    do_start(8'h7C);
    for (int i = 0; i < 20; i++) send(8'(8'h10 + i));
    check("R2 R3 wrapped ptr", word_ptr, 8'h70);
    do_stop("wrap R3");

    // R6: zero bytes
    do_start(8'h22);
    do_stop("empty R6");

    // R7: all bytes protected
    do_start(8'h10);
    wp_level = 1'b1;
    send(8'h55); send(8'h66);
    check("R7 ptr held", word_ptr, 8'h10);
    do_stop("protected R7");
    wp_level = 1'b0;

    // R7: mixed protection
    do_start(8'h9E);
    send(8'h01);
    wp_level = 1'b1; send(8'h02); wp_level = 1'b0;
    send(8'h03);
    check("R7 mixed ptr", word_ptr, 8'h90);
    do_stop("mixed R7");

    // R9: restart before stop
    do_start(8'h40);
    send(8'hEE); send(8'hEF);
    do_start(8'h48);
    send(8'h77);
    do_stop("restart R9");

    // R8: traffic during busy is ignored
    do_start(8'hC5);
    send(8'h31); send(8'h32);
    begin
      item_t it;
      it.a = 8'hC5; it.d = 8'h31; sb_q.push_back(it);
      it.a = 8'hC6; it.d = 8'h32; sb_q.push_back(it);
    end
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
    check("R8 busy", busy, 1);
    wr_start = 1'b1; wr_addr = 8'hA0; @(negedge clk); wr_start = 1'b0;
    byte_vld = 1'b1; byte_data = 8'hDD; @(negedge clk); byte_vld = 1'b0;
    stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
    check("R8 ptr during busy", word_ptr, 8'hC7);
    while (busy) @(negedge clk);
    repeat (WRC + 5) @(negedge clk);
    check("R8 no second cycle", busy, 0);
    check("R8 ptr after", word_ptr, 8'hC7);
    check("R8 queue drained", sb_q.size(), 0);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule